// File: doc/BRIEF.md
# Teletext Request and Insertion Controller

This block decides, for each video line, whether teletext data is to be fetched and placed into the line, and paces the fetch one bit at a time. A timing generator supplies the current line number, the field parity and a pixel count that rises by one every clock. When the global enable is set, the line lies inside the programmed range for the current field, and the line's disable bit is clear, the block opens a horizontal window. The window starts at a programmable pixel and lasts a programmable number of pixels. Inside it, the block raises a one-clock request pulse toward an external data source for every bit it needs.

The source answers each request with one serial bit, a fixed number of clocks later. The block samples that bit and delivers it on a bit output with a valid flag, in request order. Bits therefore leave in step with the line. The bit cadence comes from a divider whose ratio is chosen by a format select (European or WST style), so the different teletext bit rates differ only in one parameter each.

Top module: `ttx_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it is sampled high, `ttx_req`, `bit_vld` and `bit_out` are 0.
- R2: When `tt_en` is 0, no request pulse is issued.
- R3: With `field_odd`=1 a line is eligible only if `odd_first` <= `line_num` <= `odd_last`; with `field_odd`=0 the bounds are `even_first` and `even_last` (both inclusive).
- R4: Bit i of `line_mask` (bit 0 = LSB) disables line MASK_BASE+i (default lines 7 to 14); a disabled line issues no request; lines outside that span are never masked.
- R5: The first request of an eligible line is issued for pixel `win_start`, and none for any pixel at or past `win_start`+`win_len`; `ttx_req` goes high one clock after the pixel count it belongs to.
- R6: Inside the window, requests are spaced DIV clocks apart, where DIV is DIV_EURO (default 2) when `fmt_wst`=0 and DIV_WST (default 3) when `fmt_wst`=1; a line therefore carries ceil(`win_len`/DIV) requests.
- R7: If `ttx_req` is high in cycle c, the value on `ttx_dat` during cycle c+LAT (LAT default 3) appears on `bit_out` with `bit_vld`=1 in cycle c+LAT+1, and bits leave in request order.
- R8: `bit_out` is 0 whenever `bit_vld` is 0.
- R9: A window length of 0 issues no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tt_en | input | 1 | Global teletext enable |
| fmt_wst | input | 1 | Bit-rate format select: 0 European, 1 WST |
| field_odd | input | 1 | 1 during the odd field |
| line_num | input | 10 | Current line number |
| pix_cnt | input | 11 | Pixel count within the line, +1 per clock |
| win_start | input | 11 | First pixel of the request window |
| win_len | input | 11 | Window length in pixels |
| odd_first | input | 10 | First eligible line, odd field |
| odd_last | input | 10 | Last eligible line, odd field |
| even_first | input | 10 | First eligible line, even field |
| even_last | input | 10 | Last eligible line, even field |
| line_mask | input | MASK_W | Per-line disable bits |
| ttx_req | output | 1 | One-clock request for one bit |
| ttx_dat | input | 1 | Serial data answering each request |
| bit_out | output | 1 | Inserted teletext bit |
| bit_vld | output | 1 | `bit_out` holds a bit |

## Verification
The assertions take for granted that the pixel count steps by exactly one per clock across the window, and that the line number, field, enable, format and window settings stay still for the whole of a line. The divider spacing and the window bounds only hold under those conditions. The stimulus sets every configuration input at a negative edge before a line begins, holds it for the full sweep, and then drives the pixel count as a plain up-counter from zero. The data source answers exactly LAT clocks after each observed request, so the order and latency checks see a well-behaved partner.

// File: rtl/ttx_pkg.sv
package ttx_pkg;

    localparam int LINE_W = 10;
    localparam int PIX_W  = 11;

    typedef logic [LINE_W-1:0] line_t;
    typedef logic [PIX_W-1:0]  pix_t;

    typedef enum logic {
        FMT_EURO = 1'b0,
        FMT_WST  = 1'b1
    } ttx_fmt_e;

    typedef struct packed {
        line_t first;
        line_t last;
    } line_span_t;

    typedef struct packed {
        logic fire;
        logic eligible;
    } req_ctl_t;

    function automatic logic span_hit(input line_span_t s, input line_t ln);
        return (ln >= s.first) && (ln <= s.last);
    endfunction

    function automatic logic pix_in_win(input pix_t p, input pix_t st, input pix_t len);
        logic [PIX_W:0] end_x;
        end_x = {1'b0, st} + {1'b0, len};
        return ({1'b0, p} >= {1'b0, st}) && ({1'b0, p} < end_x);
    endfunction

endpackage

// File: rtl/ttx_line_gate.sv
module ttx_line_gate
    import ttx_pkg::*;
#(
    parameter int MASK_W    = 8,
    parameter int MASK_BASE = 7
) (
    input  logic              tt_en,
    input  logic              field_odd,
    input  line_t             line_num,
    input  line_span_t        odd_span,
    input  line_span_t        even_span,
    input  logic [MASK_W-1:0] line_mask,
    output logic              eligible
);
    localparam int MASK_TOP = MASK_BASE + MASK_W;

    logic        in_span;
    logic        in_mask_zone;
    logic        masked;
    logic [LINE_W-1:0] mask_idx;

    always_comb begin
        in_span      = field_odd ? span_hit(odd_span, line_num)
                                 : span_hit(even_span, line_num);
        in_mask_zone = (int'(line_num) >= MASK_BASE) && (int'(line_num) < MASK_TOP);
        mask_idx     = line_num - LINE_W'(MASK_BASE);
        masked       = 1'b0;
        for (int i = 0; i < MASK_W; i++) begin
            if (in_mask_zone && (int'(mask_idx) == i) && line_mask[i])
                masked = 1'b1;
        end
        eligible = tt_en && in_span && !masked;
    end

endmodule

// File: rtl/ttx_req_gen.sv
module ttx_req_gen
    import ttx_pkg::*;
#(
    parameter int DIV_EURO = 2,
    parameter int DIV_WST  = 3
) (
    input  logic     clk,
    input  logic     rst,
    input  ttx_fmt_e fmt,
    input  pix_t     pix_cnt,
    input  pix_t     win_start,
    input  pix_t     win_len,
    input  logic     eligible,
    output logic     req
);
    localparam int DIV_MAX = (DIV_EURO > DIV_WST) ? DIV_EURO : DIV_WST;
    localparam int CW      = (DIV_MAX < 2) ? 1 : $clog2(DIV_MAX);

    logic [CW-1:0] phase_q;
    logic [CW-1:0] div_m1;
    logic          in_win;
    req_ctl_t      ctl;

    always_comb begin
        div_m1       = (fmt == FMT_WST) ? CW'(DIV_WST - 1) : CW'(DIV_EURO - 1);
        in_win       = pix_in_win(pix_cnt, win_start, win_len);
        ctl.eligible = eligible;
        ctl.fire     = in_win && ((pix_cnt == win_start) || (phase_q == '0));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            req     <= 1'b0;
        end else begin
            if (!in_win)
                phase_q <= '0;
            else if (ctl.fire)
                phase_q <= div_m1;
            else
                phase_q <= phase_q - 1'b1;
            req <= ctl.fire && ctl.eligible;
        end
    end

    // R6: with a divider above one, two requests never sit in adjacent clocks
    a_r6_spacing: assert property (@(posedge clk) disable iff (rst)
        (req && $past(div_m1) != '0 && $stable(div_m1)) |=> !req);

    // R5: a request always belongs to a pixel inside the window
    a_r5_in_window: assert property (@(posedge clk) disable iff (rst)
        req |-> ({1'b0, $past(pix_cnt)} >= {1'b0, $past(win_start)}) &&
                ({1'b0, $past(pix_cnt)} < ({1'b0, $past(win_start)} + {1'b0, $past(win_len)})));

endmodule

// File: rtl/ttx_capture.sv
module ttx_capture #(
    parameter int LAT = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic dat_in,
    output logic bit_out,
    output logic bit_vld
);
    localparam int OW = $clog2(LAT + 3);

    logic          take;
    logic [OW-1:0] outstanding;

    generate
        if (LAT == 1) begin : g_short
            logic stage_q;
            always_ff @(posedge clk) begin
                if (rst) stage_q <= 1'b0;
                else     stage_q <= req;
            end
            assign take = stage_q;
        end else begin : g_long
            logic [LAT-1:0] stage_q;
            always_ff @(posedge clk) begin
                if (rst) stage_q <= '0;
                else     stage_q <= {stage_q[LAT-2:0], req};
            end
            assign take = stage_q[LAT-1];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_vld <= 1'b0;
            bit_out <= 1'b0;
        end else begin
            bit_vld <= take;
            bit_out <= take & dat_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            outstanding <= '0;
        else
            outstanding <= outstanding + OW'(req) - OW'(bit_vld);
    end

    // R7: every delivered bit answers an earlier request
    a_r7_no_orphan_bit: assert property (@(posedge clk) disable iff (rst)
        bit_vld |-> outstanding != '0);

    // R7: no more requests in flight than the latency allows
    a_r7_bounded_flight: assert property (@(posedge clk) disable iff (rst)
        int'(outstanding) <= LAT + 1);

    // R8: the data output is quiet without a valid flag
    a_r8_quiet_bit: assert property (@(posedge clk) disable iff (rst)
        !bit_vld |-> !bit_out);

endmodule

// File: rtl/ttx_ctrl.sv
module ttx_ctrl
    import ttx_pkg::*;
#(
    parameter int MASK_W    = 8,
    parameter int MASK_BASE = 7,
    parameter int DIV_EURO  = 2,
    parameter int DIV_WST   = 3,
    parameter int LAT       = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tt_en,
    input  logic              fmt_wst,
    input  logic              field_odd,
    input  logic [9:0]        line_num,
    input  logic [10:0]       pix_cnt,
    input  logic [10:0]       win_start,
    input  logic [10:0]       win_len,
    input  logic [9:0]        odd_first,
    input  logic [9:0]        odd_last,
    input  logic [9:0]        even_first,
    input  logic [9:0]        even_last,
    input  logic [MASK_W-1:0] line_mask,
    output logic              ttx_req,
    input  logic              ttx_dat,
    output logic              bit_out,
    output logic              bit_vld
);
    localparam int MASK_TOP = MASK_BASE + MASK_W;

    line_span_t odd_span;
    line_span_t even_span;
    ttx_fmt_e   fmt;
    logic       eligible;

    assign odd_span  = '{first: odd_first,  last: odd_last};
    assign even_span = '{first: even_first, last: even_last};
    assign fmt       = ttx_fmt_e'(fmt_wst);

    ttx_line_gate #(
        .MASK_W   (MASK_W),
        .MASK_BASE(MASK_BASE)
    ) u_gate (
        .tt_en    (tt_en),
        .field_odd(field_odd),
        .line_num (line_num),
        .odd_span (odd_span),
        .even_span(even_span),
        .line_mask(line_mask),
        .eligible (eligible)
    );

    ttx_req_gen #(
        .DIV_EURO(DIV_EURO),
        .DIV_WST (DIV_WST)
    ) u_req (
        .clk      (clk),
        .rst      (rst),
        .fmt      (fmt),
        .pix_cnt  (pix_cnt),
        .win_start(win_start),
        .win_len  (win_len),
        .eligible (eligible),
        .req      (ttx_req)
    );

    ttx_capture #(
        .LAT(LAT)
    ) u_cap (
        .clk    (clk),
        .rst    (rst),
        .req    (ttx_req),
        .dat_in (ttx_dat),
        .bit_out(bit_out),
        .bit_vld(bit_vld)
    );

    // R1: outputs cleared in the cycle after a reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (!ttx_req && !bit_vld && !bit_out));

    // R2: no request with teletext disabled
    a_r2_enable_gate: assert property (@(posedge clk) disable iff (rst)
        ttx_req |-> $past(tt_en));

    // R9: an empty window never requests
    a_r9_empty_window: assert property (@(posedge clk) disable iff (rst)
        ttx_req |-> ($past(win_len) != '0));

    // R4: a line whose disable bit is set never requests
    a_r4_masked_line: assert property (@(posedge clk) disable iff (rst)
        ttx_req |-> !((int'($past(line_num)) >= MASK_BASE) &&
                      (int'($past(line_num)) < MASK_TOP) &&
                      $past(line_mask[line_num - 10'(MASK_BASE)])));

    // R3: requests stay inside the field's line span
    a_r3_line_span: assert property (@(posedge clk) disable iff (rst)
        ttx_req |-> ($past(field_odd)
            ? ($past(line_num) >= $past(odd_first)  && $past(line_num) <= $past(odd_last))
            : ($past(line_num) >= $past(even_first) && $past(line_num) <= $past(even_last))));

endmodule

// File: tb/ttx_ctrl_bench.sv
module ttx_ctrl_bench;
    localparam int LAT   = 3;
    localparam int SWEEP = 48;

    typedef struct packed {
        logic       en;
        logic       wst;
        logic       odd;
        logic [9:0] line;
        logic [10:0] hs;
        logic [10:0] hd;
        logic [7:0] mask;
        logic [7:0] exp_n;
    } vec_t;

    // odd span 7..15, even span 9..12, mask lines 7..14
    localparam vec_t VECS [0:11] = '{
        '{1'b1, 1'b0, 1'b1, 10'd8,  11'd5,  11'd10, 8'h00, 8'd5}, // R6 euro divider
        '{1'b1, 1'b1, 1'b1, 10'd8,  11'd4,  11'd10, 8'h00, 8'd4}, // R6 wst divider
        '{1'b0, 1'b0, 1'b1, 10'd8,  11'd5,  11'd10, 8'h00, 8'd0}, // R2 disabled
        '{1'b1, 1'b0, 1'b0, 10'd8,  11'd5,  11'd10, 8'h00, 8'd0}, // R3 even below span
        '{1'b1, 1'b0, 1'b0, 10'd12, 11'd3,  11'd7,  8'h00, 8'd4}, // R3 even last line
        '{1'b1, 1'b0, 1'b1, 10'd10, 11'd5,  11'd10, 8'h08, 8'd0}, // R4 bit3 masks line 10
        '{1'b1, 1'b0, 1'b1, 10'd10, 11'd6,  11'd5,  8'hF7, 8'd3}, // R4 other bits only
        '{1'b1, 1'b0, 1'b1, 10'd15, 11'd2,  11'd1,  8'hFF, 8'd1}, // R4 line outside mask span
        '{1'b1, 1'b0, 1'b1, 10'd8,  11'd5,  11'd0,  8'h00, 8'd0}, // R9 empty window
        '{1'b1, 1'b1, 1'b1, 10'd9,  11'd20, 11'd1,  8'h00, 8'd1}, // R5 single pixel
        '{1'b1, 1'b0, 1'b1, 10'd16, 11'd5,  11'd10, 8'h00, 8'd0}, // R3 odd above span
        '{1'b1, 1'b1, 1'b1, 10'd7,  11'd10, 11'd6,  8'h00, 8'd2}  // R3 odd first line
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tt_en = 1'b0, fmt_wst = 1'b0, field_odd = 1'b1;
    logic [9:0]  line_num = '0;
    logic [10:0] pix_cnt = '0, win_start = '0, win_len = '0;
    logic [9:0]  odd_first = 10'd7, odd_last = 10'd15, even_first = 10'd9, even_last = 10'd12;
    logic [7:0]  line_mask = '0;
    logic        ttx_req, ttx_dat = 1'b0, bit_out, bit_vld;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    ttx_ctrl u_ttx_ctrl (
        .clk(clk), .rst(rst), .tt_en(tt_en), .fmt_wst(fmt_wst), .field_odd(field_odd),
        .line_num(line_num), .pix_cnt(pix_cnt), .win_start(win_start), .win_len(win_len),
        .odd_first(odd_first), .odd_last(odd_last), .even_first(even_first),
        .even_last(even_last), .line_mask(line_mask), .ttx_req(ttx_req),
        .ttx_dat(ttx_dat), .bit_out(bit_out), .bit_vld(bit_vld)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_line(input int v);
        vec_t  t;
        bit    sched [0:SWEEP+LAT+8];
        bit    expq  [0:63];
        int    n_req, n_out, first_px, last_px, bad_bit, bad_quiet;
        t = VECS[v];
        for (int i = 0; i <= SWEEP + LAT + 8; i++) sched[i] = 1'b0;
        n_req = 0; n_out = 0; first_px = -1; last_px = -1; bad_bit = 0; bad_quiet = 0;
        @(negedge clk);
        tt_en = t.en; fmt_wst = t.wst; field_odd = t.odd; line_num = t.line;
        win_start = t.hs; win_len = t.hd; line_mask = t.mask; pix_cnt = '0; ttx_dat = 1'b0;
        for (int c = 1; c <= SWEEP; c++) begin
            @(negedge clk);
            if (ttx_req) begin
                if (first_px < 0) first_px = c - 1;
                last_px = c - 1;
                expq[n_req % 64] = ((8'hB5 >> ((n_req + v) % 8)) & 8'h1) != 0;
                sched[c + LAT] = expq[n_req % 64];
                n_req++;
            end
            if (bit_vld) begin
                if (bit_out !== expq[n_out % 64]) bad_bit++;
                n_out++;
            end else if (bit_out !== 1'b0) bad_quiet++;
            ttx_dat = sched[c];
            pix_cnt = 11'(c);
        end
        // line-rule tags R2 R3 R4 R6 R9 share this count check
        check(n_req == int'(t.exp_n), $sformatf("R2/R3/R4/R6/R9 request count vec=%0d", v),
              n_req, int'(t.exp_n));
        if (t.exp_n != 0) begin
            check(first_px == int'(t.hs), $sformatf("R5 first request pixel vec=%0d", v),
                  first_px, int'(t.hs));
            check(last_px < int'(t.hs) + int'(t.hd), $sformatf("R5 last request pixel vec=%0d", v),
                  last_px, int'(t.hs) + int'(t.hd) - 1);
        end
        check(n_out == n_req, $sformatf("R7 delivered bits vec=%0d", v), n_out, n_req);
        check(bad_bit == 0, $sformatf("R7 bit value/order vec=%0d", v), bad_bit, 0);
        check(bad_quiet == 0, $sformatf("R8 bit_out low when invalid vec=%0d", v), bad_quiet, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog expired", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1: outputs low during reset
        check(!ttx_req && !bit_vld && !bit_out, "R1 outputs in reset",
              {ttx_req, bit_vld, bit_out}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!ttx_req && !bit_vld && !bit_out, "R1 outputs after reset",
              {ttx_req, bit_vld, bit_out}, 0);

        for (int v = 0; v < 12; v++) run_line(v);

        // R1: reset mid-line clears a request and in-flight bits
        @(negedge clk);
        tt_en = 1'b1; fmt_wst = 1'b0; field_odd = 1'b1; line_num = 10'd8;
        win_start = 11'd2; win_len = 11'd20; line_mask = '0; pix_cnt = '0;
        for (int c = 1; c <= 6; c++) begin
            @(negedge clk);
            pix_cnt = 11'(c);
        end
        rst = 1'b1;
        @(negedge clk);
        check(!ttx_req && !bit_vld && !bit_out, "R1 mid-line reset",
              {ttx_req, bit_vld, bit_out}, 0);
        rst = 1'b0;
        tt_en = 1'b0;
        repeat (LAT + 2) @(negedge clk);
        check(!bit_vld, "R1 no stale bit after reset", bit_vld, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule